// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when an in-order issue model leaves normal execution to run ahead speculatively, and when it comes back. It watches one issue slot per cycle. Each slot carries a destination register, two source registers, load and store flags, an address-valid flag, an off-chip miss flag and a cache line address. It also watches a miss-return port that names the tag of a completed memory request. In normal mode, a load that misses off-chip stalls the pipe. The controller then saves a checkpoint of the architectural registers, records the program counter of the stalling load, poisons that load's destination and switches to runahead mode.

In runahead mode the instructions that follow keep issuing, but every register result goes to a shadow copy, and stores are discarded. A poison bit for each register follows data dependence on the stalled load. Loads whose address is known and clean, and that miss off-chip, turn into prefetch requests, so several misses are in flight at once. A small pool of prefetch tags caps how many requests are outstanding. When the stalled load's data returns (tag 0), the checkpoint is restored in one cycle, all poison clears and the core replays from the recorded program counter.

Top module: `runahead_ctrl`

## Requirements
- R1: After synchronous reset, mode is normal (`mode_ra`=0), all poison bits are 0, and `pf_valid`, `arch_we`, `shadow_we`, `ckpt_save` and `ckpt_restore` are all 0.
- R2: In normal mode, a valid instruction that is not a store and does not block makes `arch_we`=1 with `rf_waddr` equal to its destination, on the cycle after issue. A store writes nothing. `arch_we` is never 1 in runahead mode.
- R3: In normal mode, a valid load with `iss_offchip`=1 blocks. On the next cycle `mode_ra`=1, `ckpt_save` pulses for exactly one cycle, `replay_pc` holds the load's PC, only the load's destination is poisoned, and no architectural write occurs.
- R4: In runahead mode, a valid instruction that is neither load nor store sets its destination poison to (poison of source A OR poison of source B), which may clear the bit. It raises `shadow_we` with `rf_waddr` equal to its destination.
- R5: In runahead mode, the address register of a load is source A. A load whose source A is poisoned, or whose `iss_addr_ok` is 0, issues no prefetch and poisons its destination.
- R6: In runahead mode, a load with a clean, valid address and `iss_offchip`=1 issues `pf_valid` with `pf_line`=its line, and `pf_tag` equal to the lowest free slot number in 1..MAX_PF. Its destination is poisoned. A clean load that hits clears its destination poison.
- R7: With all MAX_PF slots busy, a runahead miss only poisons its destination. A return with tag k (1..MAX_PF) frees slot k in any mode, and the slot can be allocated from the following cycle on.
- R8: In runahead mode a store changes no poison bit, raises neither write enable, and issues no prefetch.
- R9: A return with tag 0 in runahead mode gives, on the next cycle, `mode_ra`=0, a one-cycle `ckpt_restore`, all poison bits 0, and `replay_pc` still holding the blocking PC. An instruction presented in the restore cycle is dropped. `ckpt_save` and `ckpt_restore` are never high together.
- R10: A return with tag 0 in normal mode has no effect on mode or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue slot holds an instruction |
| iss_pc | input | PCW | Program counter of the instruction |
| iss_dst | input | RW | Destination register |
| iss_srca | input | RW | Source A (address register for loads) |
| iss_srcb | input | RW | Source B |
| iss_load | input | 1 | Instruction is a load |
| iss_store | input | 1 | Instruction is a store |
| iss_addr_ok | input | 1 | Load address has been computed |
| iss_offchip | input | 1 | Load misses all on-chip caches |
| iss_line | input | LINEW | Cache line address of the load |
| ret_valid | input | 1 | A memory request has completed |
| ret_tag | input | TAGW | Tag of the completed request, 0 = blocking load |
| mode_ra | output | 1 | 1 while in runahead mode |
| poison_o | output | NREGS | Poison bit per register |
| pf_valid | output | 1 | Prefetch request strobe |
| pf_line | output | LINEW | Line address to prefetch |
| pf_tag | output | TAGW | Slot tag of the prefetch |
| arch_we | output | 1 | Architectural register write enable |
| shadow_we | output | 1 | Shadow register write enable |
| rf_waddr | output | RW | Register address for either write enable |
| ckpt_save | output | 1 | Take a checkpoint of the register file |
| ckpt_restore | output | 1 | Restore the register file from the checkpoint |
| replay_pc | output | PCW | PC to resume at after restore |

## Verification
The case that needs the most care is the blocking load's return landing in the same cycle as a runahead load that would otherwise allocate a prefetch slot. The restore must win, so no prefetch goes out, poison clears and the instruction is dropped. The bench drives this case directly, and the random phase reaches it often, because tag 0 returns land on random instruction mixes. A second overlap is a slot release meeting an allocation in the same cycle. The bench fills every slot, frees one while a miss issues, and expects that miss to be poisoned only, with the freed tag handed out on the next miss.

// File: rtl/runahead_pkg.sv
`timescale 1ns/1ps
package runahead_pkg;
  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_RUNAHEAD = 1'b1
  } ra_mode_e;
endpackage

// File: rtl/ra_poison_tracker.sv
`timescale 1ns/1ps
// One poison flag per architectural register; clear-all wins over a write.
module ra_poison_tracker #(
  parameter int NREGS = 16,
  parameter int RW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic [RW-1:0]    widx,
  input  logic             wval,
  output logic [NREGS-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bits <= '0;
    end else if (wr) begin
      bits[widx] <= wval;
    end
  end
endmodule

// File: rtl/ra_prefetch_slots.sv
`timescale 1ns/1ps
// Pool of prefetch tags 1..NSLOT; lowest free slot is offered each cycle.
module ra_prefetch_slots #(
  parameter int NSLOT = 4,
  parameter int TW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             rel,
  input  logic [TW-1:0]    rel_tag,
  output logic             avail,
  output logic [TW-1:0]    next_tag,
  output logic [NSLOT-1:0] busy
);
  always_comb begin
    avail    = 1'b0;
    next_tag = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (!busy[k]) begin
        avail    = 1'b1;
        next_tag = TW'(k + 1);
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [TW-1:0] MYTAG = TW'(g + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        busy[g] <= 1'b0;
      end else if (rel && rel_tag == MYTAG) begin
        busy[g] <= 1'b0;
      end else if (alloc && avail && next_tag == MYTAG) begin
        busy[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/runahead_ctrl.sv
`timescale 1ns/1ps
module runahead_ctrl #(
  parameter int NREGS  = 16,
  parameter int PCW    = 32,
  parameter int LINEW  = 26,
  parameter int MAX_PF = 4,
  parameter int RW     = $clog2(NREGS),
  parameter int TAGW   = $clog2(MAX_PF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [PCW-1:0]   iss_pc,
  input  logic [RW-1:0]    iss_dst,
  input  logic [RW-1:0]    iss_srca,
  input  logic [RW-1:0]    iss_srcb,
  input  logic             iss_load,
  input  logic             iss_store,
  input  logic             iss_addr_ok,
  input  logic             iss_offchip,
  input  logic [LINEW-1:0] iss_line,
  input  logic             ret_valid,
  input  logic [TAGW-1:0]  ret_tag,
  output logic             mode_ra,
  output logic [NREGS-1:0] poison_o,
  output logic             pf_valid,
  output logic [LINEW-1:0] pf_line,
  output logic [TAGW-1:0]  pf_tag,
  output logic             arch_we,
  output logic             shadow_we,
  output logic [RW-1:0]    rf_waddr,
  output logic             ckpt_save,
  output logic             ckpt_restore,
  output logic [PCW-1:0]   replay_pc
);
  import runahead_pkg::*;

  ra_mode_e mode_q;
  logic in_ra, restore_go, block_go, ra_issue;
  logic src_a_bad, src_b_bad, addr_clean, pf_go;
  logic pois_wr, pois_wval, dep_poison;
  logic slot_avail;
  logic [TAGW-1:0] slot_tag;
  logic [MAX_PF-1:0] slot_busy;

  assign in_ra      = (mode_q == MODE_RUNAHEAD);
  assign restore_go = in_ra && ret_valid && (ret_tag == '0);
  assign block_go   = !in_ra && iss_valid && iss_load && iss_offchip;
  assign ra_issue   = in_ra && !restore_go && iss_valid;

  assign src_a_bad  = poison_o[iss_srca];
  assign src_b_bad  = poison_o[iss_srcb];
  assign addr_clean = iss_addr_ok && !src_a_bad;
  assign pf_go      = ra_issue && iss_load && addr_clean && iss_offchip && slot_avail;

  always_comb begin
    if (iss_load) dep_poison = !addr_clean || iss_offchip;
    else          dep_poison = src_a_bad || src_b_bad;
  end

  assign pois_wr   = block_go || (ra_issue && !iss_store);
  assign pois_wval = block_go ? 1'b1 : dep_poison;

  ra_poison_tracker #(.NREGS(NREGS), .RW(RW)) u_poison (
    .clk  (clk),
    .rst  (rst),
    .clr  (restore_go),
    .wr   (pois_wr),
    .widx (iss_dst),
    .wval (pois_wval),
    .bits (poison_o)
  );

  ra_prefetch_slots #(.NSLOT(MAX_PF), .TW(TAGW)) u_slots (
    .clk      (clk),
    .rst      (rst),
    .alloc    (pf_go),
    .rel      (ret_valid && ret_tag != '0),
    .rel_tag  (ret_tag),
    .avail    (slot_avail),
    .next_tag (slot_tag),
    .busy     (slot_busy)
  );

  assign mode_ra = in_ra;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_NORMAL;
      ckpt_save    <= 1'b0;
      ckpt_restore <= 1'b0;
      arch_we      <= 1'b0;
      shadow_we    <= 1'b0;
      pf_valid     <= 1'b0;
      rf_waddr     <= '0;
      pf_line      <= '0;
      pf_tag       <= '0;
      replay_pc    <= '0;
    end else begin
      if (restore_go)    mode_q <= MODE_NORMAL;
      else if (block_go) mode_q <= MODE_RUNAHEAD;
      ckpt_save    <= block_go;
      ckpt_restore <= restore_go;
      if (block_go) replay_pc <= iss_pc;
      arch_we      <= !in_ra && iss_valid && !iss_store && !block_go;
      shadow_we    <= ra_issue && !iss_store;
      rf_waddr     <= iss_dst;
      pf_valid     <= pf_go;
      pf_line      <= iss_line;
      pf_tag       <= slot_tag;
    end
  end
endmodule

// File: rtl/runahead_ctrl_chk.sv
`timescale 1ns/1ps
module runahead_ctrl_chk #(
  parameter int NREGS  = 16,
  parameter int MAX_PF = 4,
  parameter int RW     = 4,
  parameter int TAGW   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_ra,
  input logic [NREGS-1:0] poison_o,
  input logic             pf_valid,
  input logic [TAGW-1:0]  pf_tag,
  input logic             arch_we,
  input logic             shadow_we,
  input logic             ckpt_save,
  input logic             ckpt_restore
);
  a_r9_save_restore_apart: assert property (@(posedge clk) disable iff (rst)
    !(ckpt_save && ckpt_restore));
  a_r2_no_arch_write_in_ra: assert property (@(posedge clk) disable iff (rst)
    mode_ra |-> !arch_we);
  a_r4_shadow_only_in_ra: assert property (@(posedge clk) disable iff (rst)
    shadow_we |-> mode_ra);
  a_r3_entry_saves: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_ra) |-> (ckpt_save && $countones(poison_o) == 1));
  a_r9_exit_restores: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_ra) |-> (ckpt_restore && poison_o == '0));
  a_r6_prefetch_tag_range: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (mode_ra && pf_tag != '0 && pf_tag <= TAGW'(MAX_PF)));
  a_r10_restore_needs_ra: assert property (@(posedge clk) disable iff (rst)
    ckpt_restore |-> $past(mode_ra));
endmodule

bind runahead_ctrl runahead_ctrl_chk #(
  .NREGS(NREGS), .MAX_PF(MAX_PF), .RW(RW), .TAGW(TAGW)
) u_chk (
  .clk(clk), .rst(rst), .mode_ra(mode_ra), .poison_o(poison_o),
  .pf_valid(pf_valid), .pf_tag(pf_tag), .arch_we(arch_we),
  .shadow_we(shadow_we), .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore)
);

// File: tb/runahead_ctrl_test.sv
`timescale 1ns/1ps
module runahead_ctrl_test;
  localparam int NREGS = 16, PCW = 32, LINEW = 26, MAX_PF = 4, RW = 4, TAGW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic iss_valid, iss_load, iss_store, iss_addr_ok, iss_offchip, ret_valid;
  logic [PCW-1:0] iss_pc;
  logic [RW-1:0] iss_dst, iss_srca, iss_srcb;
  logic [LINEW-1:0] iss_line;
  logic [TAGW-1:0] ret_tag;
  logic mode_ra, pf_valid, arch_we, shadow_we, ckpt_save, ckpt_restore;
  logic [NREGS-1:0] poison_o;
  logic [LINEW-1:0] pf_line;
  logic [TAGW-1:0] pf_tag;
  logic [RW-1:0] rf_waddr;
  logic [PCW-1:0] replay_pc;

  runahead_ctrl #(.NREGS(NREGS), .PCW(PCW), .LINEW(LINEW), .MAX_PF(MAX_PF)) uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_dst(iss_dst),
    .iss_srca(iss_srca), .iss_srcb(iss_srcb), .iss_load(iss_load), .iss_store(iss_store),
    .iss_addr_ok(iss_addr_ok), .iss_offchip(iss_offchip), .iss_line(iss_line),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .mode_ra(mode_ra), .poison_o(poison_o),
    .pf_valid(pf_valid), .pf_line(pf_line), .pf_tag(pf_tag), .arch_we(arch_we),
    .shadow_we(shadow_we), .rf_waddr(rf_waddr), .ckpt_save(ckpt_save),
    .ckpt_restore(ckpt_restore), .replay_pc(replay_pc));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit m_mode;
  logic [NREGS-1:0] m_pois;
  logic [MAX_PF-1:0] m_busy;
  logic [PCW-1:0] m_replay;
  // expected outputs
  bit e_save, e_rest, e_arch, e_sh, e_pf;
  logic [RW-1:0] e_waddr;
  logic [LINEW-1:0] e_line;
  logic [TAGW-1:0] e_tag;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TAGW-1:0] lowest_free(input logic [MAX_PF-1:0] b);
    for (int k = MAX_PF - 1; k >= 0; k--) if (!b[k]) lowest_free = TAGW'(k + 1);
    if (&b) lowest_free = '0;
  endfunction

  task automatic predict();
    bit restore, block, ra_iss, pa, pb, clean, dep;
    logic [TAGW-1:0] ft;
    restore = m_mode && ret_valid && ret_tag == 0;
    block   = !m_mode && iss_valid && iss_load && iss_offchip;
    ra_iss  = m_mode && !restore && iss_valid;
    pa = m_pois[iss_srca]; pb = m_pois[iss_srcb];
    clean = iss_addr_ok && !pa;
    ft = lowest_free(m_busy);
    e_pf    = ra_iss && iss_load && clean && iss_offchip && (ft != 0);
    e_save  = block; e_rest = restore;
    e_arch  = !m_mode && iss_valid && !iss_store && !block;
    e_sh    = ra_iss && !iss_store;
    e_waddr = iss_dst; e_line = iss_line; e_tag = ft;
    dep = iss_load ? (!clean || iss_offchip) : (pa || pb);
    if (ret_valid && ret_tag != 0 && ret_tag <= MAX_PF) m_busy[ret_tag-1] = 1'b0;
    if (e_pf) m_busy[ft-1] = 1'b1;
    if (restore) begin m_pois = '0; m_mode = 0; end
    else if (block) begin m_pois[iss_dst] = 1'b1; m_mode = 1; m_replay = iss_pc; end
    else if (ra_iss && !iss_store) m_pois[iss_dst] = dep;
  endtask

  task automatic compare();
    chk("R3/R9 mode", mode_ra, m_mode);
    chk("R4 poison vector", poison_o, m_pois);
    chk("R3 ckpt_save", ckpt_save, e_save);
    chk("R9 ckpt_restore", ckpt_restore, e_rest);
    chk("R2 arch_we", arch_we, e_arch);
    chk("R4 shadow_we", shadow_we, e_sh);
    if (e_arch || e_sh) chk("R2/R4 rf_waddr", rf_waddr, e_waddr);
    chk("R6 pf_valid", pf_valid, e_pf);
    if (e_pf) begin
      chk("R6 pf_line", pf_line, e_line);
      chk("R6 pf_tag", pf_tag, e_tag);
    end
    if (e_rest) chk("R9 replay_pc", replay_pc, m_replay);
  endtask

  task automatic issue(input bit v, input logic [PCW-1:0] pc, input int d, input int sa,
                       input int sb, input bit ld, input bit st, input bit ok, input bit off,
                       input logic [LINEW-1:0] ln, input bit rv, input int rt);
    iss_valid = v; iss_pc = pc; iss_dst = RW'(d); iss_srca = RW'(sa); iss_srcb = RW'(sb);
    iss_load = ld; iss_store = st; iss_addr_ok = ok; iss_offchip = off; iss_line = ln;
    ret_valid = rv; ret_tag = TAGW'(rt);
    predict();
    @(posedge clk); #1;
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    m_mode = 0; m_pois = '0; m_busy = '0; m_replay = '0;
    // R1 reset state
    chk("R1 mode", mode_ra, 0); chk("R1 poison", poison_o, 0);
    chk("R1 strobes", {pf_valid, arch_we, shadow_we, ckpt_save, ckpt_restore}, 0);
    // R2 normal writes, store writes nothing
    issue(1, 32'h40, 7, 1, 2, 0, 0, 1, 0, 0, 0, 0);
    chk("R2 normal alu write", {arch_we, rf_waddr}, {1'b1, 4'd7});
    issue(1, 32'h44, 7, 1, 2, 0, 1, 1, 0, 0, 0, 0);
    chk("R2 store no write", arch_we, 0);
    // R10 tag 0 return in normal mode
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R10 ignored in normal", {mode_ra, ckpt_restore}, 0);
    // R3 blocking load
    issue(1, 32'h100, 3, 1, 1, 1, 0, 1, 1, 26'h11, 0, 0);
    chk("R3 entry", {mode_ra, ckpt_save, arch_we, poison_o}, {3'b110, 16'h0008});
    chk("R3 replay pc", replay_pc, 32'h100);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 save one pulse", ckpt_save, 0);
    // R4 propagation and clearing
    issue(1, 32'h104, 5, 2, 3, 0, 0, 1, 0, 0, 0, 0);
    chk("R4 dst poisoned", {shadow_we, poison_o[5]}, 2'b11);
    issue(1, 32'h108, 3, 1, 2, 0, 0, 1, 0, 0, 0, 0);
    chk("R4 dst cleared", poison_o[3], 0);
    // R5 poisoned address and invalid address
    issue(1, 32'h10c, 6, 5, 0, 1, 0, 1, 1, 26'h22, 0, 0);
    chk("R5 poisoned address", {pf_valid, poison_o[6]}, 2'b01);
    issue(1, 32'h110, 8, 1, 0, 1, 0, 0, 1, 26'h23, 0, 0);
    chk("R5 address not ready", {pf_valid, poison_o[8]}, 2'b01);
    // R6 fill slots
    for (int i = 0; i < MAX_PF; i++) begin
      issue(1, 32'h200 + i, 9, 1, 0, 1, 0, 1, 1, 26'h300 + i, 0, 0);
      chk("R6 prefetch tag", {pf_valid, pf_tag}, {1'b1, 3'(i + 1)});
    end
    // R6 clean hit clears dst
    issue(1, 32'h210, 9, 1, 0, 1, 0, 1, 0, 0, 0, 0);
    chk("R6 hit clears", poison_o[9], 0);
    // R7 cap, release meeting allocation
    issue(1, 32'h214, 10, 1, 0, 1, 0, 1, 1, 26'h400, 0, 0);
    chk("R7 capped", {pf_valid, poison_o[10]}, 2'b01);
    issue(1, 32'h218, 11, 1, 0, 1, 0, 1, 1, 26'h401, 1, 2);
    chk("R7 release same cycle", pf_valid, 0);
    issue(1, 32'h21c, 12, 1, 0, 1, 0, 1, 1, 26'h402, 0, 0);
    chk("R7 freed tag reused", {pf_valid, pf_tag}, {1'b1, 3'd2});
    // R8 store in runahead
    issue(1, 32'h220, 5, 1, 1, 0, 1, 1, 0, 0, 0, 0);
    chk("R8 store inert", {pf_valid, shadow_we, arch_we, poison_o[5]}, 4'b0001);
    // R9 restore coinciding with a load miss
    issue(1, 32'h224, 13, 1, 0, 1, 0, 1, 1, 26'h500, 1, 0);
    chk("R9 restore", {mode_ra, ckpt_restore, pf_valid, poison_o}, {3'b010, 16'h0});
    chk("R9 replay pc", replay_pc, 32'h100);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 restore one pulse", ckpt_restore, 0);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      bit rv; int rt;
      rv = 0; rt = 0;
      if (m_mode && $urandom_range(99) < 8) rv = 1;
      else if ($urandom_range(99) < 20) begin
        int s;
        s = $urandom_range(MAX_PF - 1);
        if (m_busy[s]) begin rv = 1; rt = s + 1; end
      end else if ($urandom_range(99) < 2) rv = 1;
      begin
        int kind;
        kind = $urandom_range(99);
        issue($urandom_range(99) < 85, $urandom, $urandom_range(NREGS - 1),
              $urandom_range(NREGS - 1), $urandom_range(NREGS - 1),
              kind < 35, kind >= 35 && kind < 50, $urandom_range(99) < 85,
              $urandom_range(99) < 45, LINEW'($urandom), rv, rt);
      end
    end
    finish_run();
  end
endmodule